// File: doc/BRIEF.md
# HDLC Serial Frame Transmitter

The block takes frames as a stream of bytes and puts them on a single serial line as bit-stuffed HDLC frames. The first byte of a frame is the address, the second is the control byte, and any bytes after that are payload. The block wraps each frame in 0x7E flag bytes and appends a 16-bit frame check sequence. It inserts a zero after every run of five ones inside the frame. While no frame is waiting, it keeps the line busy with back-to-back flags.

Bytes enter through a valid/ready handshake. A last-byte marker closes the frame. One byte is held ahead of the serializer, so the next byte can be loaded while the current one is shifted out. The line advances one bit for each pulse of a bit-enable strobe. The byte side stalls while a stuff bit is pending, so the rate at which bytes are accepted follows the amount of stuffing.

A frame that has only one byte has no control byte. Such a frame is taken from the input and dropped, and nothing is sent for it.

The sequencer has three states:
- `ST_FLAG` sends a flag byte.
  - At the end of the flag, if a first byte is held, the transition *open* goes to `ST_DATA`.
  - Otherwise the transition *idle* stays in `ST_FLAG`.
- `ST_DATA` shifts out bytes.
  - At each byte boundary the transition *next byte* loads the held byte and stays in `ST_DATA`.
  - After the last byte, or when no byte is held, the transition *close* goes to `ST_FCS`.
- `ST_FCS` shifts out the 16 check bits.
  - After the last check bit, the transition *tail* goes back to `ST_FLAG`.
  - That flag closes the current frame and can also open the next one.

A pending stuff bit takes priority in every state. While it is output, the sequencer does not advance.

Top module: `hdlc_bit_tx`

## Requirements
- R1: Reset values:
  - `tx_bit` is 0 and `in_ready` is 1 after reset.
  - From the first strobe on, the line carries 0x7E flags back to back, each sent least significant bit first.
- R2: Frame content:
  - A frame is sent as opening flag, then all of its bytes in arrival order, then the check sequence, then the closing flag.
  - Every byte goes out least significant bit first.
- R3: Zero insertion:
  - Inside the frame bytes and the check bits, a 0 is inserted after every five consecutive 1 bits.
  - Flags are never stuffed, so the line never carries more than six consecutive ones.
- R4: Check sequence:
  - The CRC uses the polynomial x^16+x^12+x^5+1 in bit-reflected form (0x8408) and starts at 0xFFFF.
  - It covers only the unstuffed frame bits.
  - Its ones' complement is sent low bit first.
  - A CRC run over the frame bytes followed by the check bytes therefore ends at 0xF0B8.
- R5: A frame of a single byte (last marker on its first byte) is accepted and dropped. The line keeps sending flags.
- R6: A frame of exactly two bytes (address and control) is sent in full with its check sequence.
- R7: Handshake rules:
  - `in_ready` is low while a byte is held.
  - `in_ready` is low for the whole bit period that precedes a stuffed zero.
- R8: `tx_bit` changes only on a clock edge where `bit_en` is high.
- R9: If the first byte of the next frame is already held when a closing flag ends, the next frame starts at once. The closing flag is then the only flag between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Advances the line by one bit |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte value |
| in_last | input | 1 | Byte closes the frame |
| in_ready | output | 1 | Byte is taken on this edge when valid |
| tx_bit | output | 1 | Serial line |

## Verification
The bench decodes the serial line with its own flag search and zero removal. A design that stuffs in the wrong place either breaks the byte count of a frame or shows seven ones in a row. Frames made of 0xFF bytes put stuff bits on the last data bit and on the check bits, where a design that mishandles the byte-to-check boundary would corrupt the CRC residue. A one-byte frame must vanish without disturbing the flags or the frame that follows. A pair of frames sent without a gap must share a single flag, which a sequencer that always idles after a frame would not do. Every stuffed zero is also checked against the ready level in the bit period before it, which catches a byte side that keeps accepting during a stuff bit.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
    localparam int unsigned FLAG_LEN = 8;
    localparam logic [FLAG_LEN-1:0] FLAG_PATTERN = 8'h7E;

    typedef enum logic [1:0] {
        ST_FLAG,
        ST_DATA,
        ST_FCS
    } tx_state_e;
endpackage

// File: rtl/hdlc_tx_inbuf.sv
module hdlc_tx_inbuf #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              block,
    input  logic              take,
    output logic              hold_v,
    output logic [DATA_W-1:0] hold_d,
    output logic              hold_last
);
    logic first_q;
    logic accept;

    assign in_ready = !hold_v && !block;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_v    <= 1'b0;
            hold_d    <= '0;
            hold_last <= 1'b0;
            first_q   <= 1'b1;
        end else begin
            if (take) begin
                hold_v <= 1'b0;
            end
            if (accept) begin
                first_q <= in_last;
                // a frame whose first byte is also its last is dropped
                if (!(first_q && in_last)) begin
                    hold_v    <= 1'b1;
                    hold_d    <= in_data;
                    hold_last <= in_last;
                end
            end
        end
    end
endmodule

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc #(
    parameter int unsigned   CRC_W = 16,
    parameter logic [CRC_W-1:0] POLY = 16'h8408,
    parameter logic [CRC_W-1:0] SEED = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             feed,
    input  logic             drain,
    input  logic             din,
    output logic [CRC_W-1:0] crc_q
);
    logic fb;
    assign fb = crc_q[0] ^ din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= SEED;
        end else if (init) begin
            crc_q <= SEED;
        end else if (feed) begin
            crc_q <= {1'b0, crc_q[CRC_W-1:1]} ^ (fb ? POLY : '0);
        end else if (drain) begin
            crc_q <= {1'b1, crc_q[CRC_W-1:1]};
        end
    end
endmodule

// File: rtl/hdlc_tx_stuff.sv
module hdlc_tx_stuff #(
    parameter int unsigned RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic stuffable,
    input  logic bit_in,
    output logic pend
);
    localparam int unsigned CW = $clog2(RUN_LEN + 1);
    logic [CW-1:0] ones;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
            ones <= '0;
        end else if (adv) begin
            if (pend) begin
                pend <= 1'b0;
                ones <= '0;
            end else if (stuffable && bit_in) begin
                if (ones == CW'(RUN_LEN - 1)) begin
                    pend <= 1'b1;
                    ones <= '0;
                end else begin
                    ones <= ones + 1'b1;
                end
            end else begin
                ones <= '0;
            end
        end
    end
endmodule

// File: rtl/hdlc_bit_tx.sv
module hdlc_bit_tx
    import hdlc_tx_pkg::*;
#(
    parameter int unsigned   DATA_W   = 8,
    parameter int unsigned   RUN_LEN  = 5,
    parameter int unsigned   CRC_W    = 16,
    parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408,
    parameter logic [CRC_W-1:0] CRC_SEED = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              tx_bit
);
    localparam int unsigned CNT_W = $clog2(CRC_W);

    tx_state_e          state, nxt_state;
    logic [CNT_W-1:0]   cnt, nxt_cnt;
    logic [DATA_W-1:0]  shreg;
    logic               cur_last;
    logic               pend;
    logic               step;
    logic               hold_v, hold_last;
    logic [DATA_W-1:0]  hold_d;
    logic [CRC_W-1:0]   crc_q;
    logic               do_load, do_init, do_feed, do_drain, do_shift;
    logic               nbit, stuffable;

    assign step = bit_en && !pend;

    hdlc_tx_inbuf #(.DATA_W(DATA_W)) u_inbuf (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .block(pend), .take(step && do_load),
        .hold_v(hold_v), .hold_d(hold_d), .hold_last(hold_last)
    );

    hdlc_tx_crc #(.CRC_W(CRC_W), .POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
        .clk(clk), .rst_n(rst_n),
        .init(step && do_init), .feed(step && do_feed),
        .drain(step && do_drain), .din(nbit), .crc_q(crc_q)
    );

    hdlc_tx_stuff #(.RUN_LEN(RUN_LEN)) u_stuff (
        .clk(clk), .rst_n(rst_n), .adv(bit_en),
        .stuffable(stuffable), .bit_in(nbit), .pend(pend)
    );

    // next state and per-bit controls
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt + 1'b1;
        do_load   = 1'b0;
        do_init   = 1'b0;
        do_feed   = 1'b0;
        do_drain  = 1'b0;
        do_shift  = 1'b0;
        stuffable = 1'b0;
        nbit      = 1'b0;
        unique case (state)
            ST_FLAG: begin
                nbit = FLAG_PATTERN[cnt[2:0]];
                if (cnt == CNT_W'(FLAG_LEN - 1)) begin
                    nxt_cnt = '0;
                    if (hold_v) begin
                        nxt_state = ST_DATA;
                        do_load   = 1'b1;
                        do_init   = 1'b1;
                    end
                end
            end
            ST_DATA: begin
                nbit      = shreg[0];
                stuffable = 1'b1;
                do_feed   = 1'b1;
                do_shift  = 1'b1;
                if (cnt == CNT_W'(DATA_W - 1)) begin
                    nxt_cnt = '0;
                    if (!cur_last && hold_v) begin
                        do_load = 1'b1;
                    end else begin
                        nxt_state = ST_FCS;
                    end
                end
            end
            ST_FCS: begin
                nbit      = ~crc_q[0];
                stuffable = 1'b1;
                do_drain  = 1'b1;
                if (cnt == CNT_W'(CRC_W - 1)) begin
                    nxt_cnt   = '0;
                    nxt_state = ST_FLAG;
                end
            end
            default: begin
                nxt_state = ST_FLAG;
                nxt_cnt   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_FLAG;
            cnt      <= '0;
            shreg    <= '0;
            cur_last <= 1'b0;
        end else if (step) begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
            if (do_load) begin
                shreg    <= hold_d;
                cur_last <= hold_last;
            end else if (do_shift) begin
                shreg <= {1'b0, shreg[DATA_W-1:1]};
            end
        end
    end

    // line output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_bit <= 1'b0;
        end else if (bit_en) begin
            tx_bit <= pend ? 1'b0 : nbit;
        end
    end
endmodule

module hdlc_bit_tx_chk
    import hdlc_tx_pkg::*;
#(
    parameter int unsigned   CRC_W    = 16,
    parameter logic [CRC_W-1:0] CRC_SEED = 16'hFFFF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             in_valid,
    input logic             in_last,
    input logic             in_ready,
    input logic             tx_bit,
    input logic             pend,
    input tx_state_e        state,
    input logic [CRC_W-1:0] crc_q
);
    logic       be_q;
    logic [3:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            be_q <= 1'b0;
            run  <= '0;
        end else begin
            be_q <= bit_en;
            if (be_q) begin
                run <= tx_bit ? ((run == 4'hF) ? run : run + 1'b1) : 4'h0;
            end
        end
    end

    assert_run_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run <= 4'd6);

    assert_pend_after_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> tx_bit);

    assert_line_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_en) |-> $stable(tx_bit));

    assert_held_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_last) |=> !in_ready);

    assert_crc_seed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_DATA) |-> (crc_q == CRC_SEED));
endmodule

bind hdlc_bit_tx hdlc_bit_tx_chk #(.CRC_W(CRC_W), .CRC_SEED(CRC_SEED)) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .tx_bit(tx_bit),
    .pend(pend), .state(state), .crc_q(crc_q)
);

// File: tb/sim_hdlc_bit_tx.sv
`timescale 1ns/1ps
module sim_hdlc_bit_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       tx_bit;

    always #2.5 clk = ~clk;

    hdlc_bit_tx u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_ready(in_ready), .tx_bit(tx_bit)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] exp_bytes[$];
    int         exp_len[$];
    int         n_sent = 0;

    bit   rx_bits[$];
    int   ones = 0;
    bit   synced = 1'b0;
    int   idle_flags = 0;
    int   last_gap = -1;
    int   frames_rx = 0;
    int   aborts = 0;
    bit   prev_rdy = 1'b1;
    bit   be_drv = 1'b0;
    logic prev_tx = 1'b0;
    int   be_div = 1;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ 16'h8408;
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic end_frame();
        int nb = rx_bits.size();
        int n;
        int L;
        int bad;
        logic [7:0] b;
        logic [15:0] c;
        if (nb % 8 != 0 || nb < 32) begin
            check(1'b0, "R2", "frame bit count", nb, 32);
            return;
        end
        n = nb / 8;
        if (exp_len.size() == 0) begin
            check(1'b0, "R5", "unexpected frame length", n, 0);
            return;
        end
        L = exp_len.pop_front();
        check(n == L + 2, "R2", "frame byte count", n, L + 2);
        bad = 0;
        c = 16'hFFFF;
        for (int k = 0; k < n; k++) begin
            for (int j = 0; j < 8; j++) b[j] = rx_bits[k*8 + j];
            c = crc_byte(c, b);
            if (k < L) begin
                if (exp_bytes.size() == 0 || exp_bytes[0] != b) bad++;
                if (exp_bytes.size() != 0) void'(exp_bytes.pop_front());
            end
        end
        check(bad == 0, "R2", "payload byte mismatches", bad, 0);
        check(c == 16'hF0B8, "R4", "check residue", c, 16'hF0B8);
        last_gap = idle_flags;
        idle_flags = 0;
        frames_rx++;
    endtask

    task automatic rx_bit(bit b);
        if (b) begin
            ones++;
            rx_bits.push_back(1'b1);
            if (ones == 7) begin
                aborts++;
                check(1'b0, "R3", "ones run on line", ones, 6);
            end
        end else begin
            if (ones == 5) begin
                check(prev_rdy == 1'b0, "R7", "ready before stuffed zero", prev_rdy, 0);
            end else if (ones == 6) begin
                if (rx_bits.size() >= 7) begin
                    repeat (7) void'(rx_bits.pop_back());
                end
                if (synced) begin
                    if (rx_bits.size() > 0) end_frame();
                    else idle_flags++;
                end
                rx_bits.delete();
                synced = 1'b1;
            end else begin
                rx_bits.push_back(1'b0);
            end
            ones = 0;
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_tx = tx_bit;
        end else begin
            if (be_drv) begin
                rx_bit(tx_bit);
                prev_rdy = in_ready;
            end else begin
                check(tx_bit === prev_tx, "R8", "line moved without strobe", tx_bit, prev_tx);
            end
            prev_tx = tx_bit;
            be_drv = ($urandom_range(be_div - 1, 0) == 0);
            bit_en = be_drv;
        end
    end

    task automatic send_frame(int len, int ff_pct);
        logic [7:0] d;
        for (int i = 0; i < len; i++) begin
            d = ($urandom_range(99, 0) < ff_pct) ? 8'hFF : 8'($urandom);
            if (len >= 2) exp_bytes.push_back(d);
            in_valid = 1'b1;
            in_data  = d;
            in_last  = (i == len - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        if (len >= 2) begin
            exp_len.push_back(len);
            n_sent++;
        end
    endtask

    task automatic send_bytes(logic [7:0] a, logic [7:0] c);
        exp_bytes.push_back(a);
        exp_bytes.push_back(c);
        in_valid = 1'b1;
        in_data = a;
        in_last = 1'b0;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_data = c;
        in_last = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_last = 1'b0;
        exp_len.push_back(2);
        n_sent++;
    endtask

    task automatic drain();
        int t = 0;
        while (exp_len.size() != 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (30 * be_div) @(negedge clk);
    endtask

    int f0;
    int g0;

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_bit == 1'b0, "R1", "line after reset", tx_bit, 0);
        check(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);

        repeat (40) @(negedge clk);
        check(idle_flags >= 3, "R1", "idle flags seen", idle_flags, 3);
        check(frames_rx == 0, "R1", "frames while idle", frames_rx, 0);

        // minimal frame: address and control only
        send_bytes(8'h77, 8'h03);
        drain();
        check(frames_rx == 1, "R6", "two-byte frame received", frames_rx, 1);

        // all-ones payload forces stuffing on data and check bits
        send_frame(6, 100);
        drain();
        check(frames_rx == 2, "R3", "all-ones frame received", frames_rx, 2);

        // single-byte frame is dropped
        f0 = frames_rx;
        g0 = idle_flags;
        send_frame(1, 0);
        repeat (80) @(negedge clk);
        check(frames_rx == f0, "R5", "frames after one-byte frame", frames_rx, f0);
        check(idle_flags >= g0 + 5, "R5", "flags continue", idle_flags, g0 + 5);
        send_frame(3, 0);
        drain();
        check(frames_rx == f0 + 1, "R5", "frame after dropped one", frames_rx, f0 + 1);

        // back-to-back frames share one flag
        send_frame(3, 0);
        send_frame(4, 30);
        drain();
        check(last_gap == 0, "R9", "idle flags between back-to-back frames", last_gap, 0);

        // random traffic
        for (int r = 0; r < 30; r++) begin
            be_div = $urandom_range(3, 1);
            send_frame($urandom_range(8, 1), ($urandom_range(2, 0) == 0) ? 70 : 10);
            repeat ($urandom_range(20, 0)) @(negedge clk);
        end
        drain();
        check(exp_len.size() == 0, "R2", "frames outstanding", exp_len.size(), 0);
        check(frames_rx == n_sent, "R2", "frames received vs sent", frames_rx, n_sent);
        check(aborts == 0, "R3", "seven-ones runs", aborts, 0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #750000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule